// File: doc/BRIEF.md
# Daisy-Chained Strip Front-End Digital Core

This block is the digital half of a 64-channel strip readout chip. Several of these chips sit in a row, and each row is read by a controller at either end. The block receives one discriminator bit per channel and does two jobs. It forms a fast trigger OR, which it merges with the OR coming from one neighbour and passes to the other neighbour. It also keeps snapshots of the hit pattern, which it later sends out on a one-bit serial line. A direction input chooses, at any time, which side receives the OR and the serial data. The opposite side is then the upstream neighbour.

A trigger-acknowledge strobe stores the data-masked hit word into one of four event buffers, together with the 2-bit code that names the buffer. A read-event strobe loads the named buffer into the output shift register. The block then sends a short, zero-suppressed record. After the last bit of its own record, it forwards the upstream neighbour's serial stream with no gap. All chips in a row receive the read strobe in the same cycle, so the records of the whole row arrive at the controller back to back.

Top module: `strip_fe_core`

## Requirements
- R1: The local trigger OR is the OR of `hit_i & ~trig_mask_i`. A mask bit of 1 blocks its channel, and any set of channels may be blocked.
- R2: The OR output on the selected side is a register. It carries the local OR merged with the OR input from the opposite side, one clock after those inputs are sampled. The OR output on the unselected side is 0, and the OR input on the selected side is ignored.
- R3: `dir_right_i` = 1 selects the right side for both the OR and the serial data, and 0 selects the left side. A change in this input takes effect at the next clock edge.
- R4: When `ack_i` is high, the buffer addressed by `ack_code_i` is written with `hit_i & ~data_mask_i` and with the code itself. A later write to the same buffer overwrites it.
- R5: The data mask acts only on stored data and the trigger mask acts only on the OR. Neither mask affects the other path.
- R6: A read strobe sampled at edge E0 loads the buffer addressed by `rd_addr_i`. Record bit k appears on the selected serial output after edge E(k+1). The record order is: bit 0 is the flag, bit 1 is code bit 1, bit 2 is code bit 0, and bits 3 to 66 are channels 0 to 63.
- R7: The flag is 1 exactly when the stored word is non-zero. When the flag is 0, the record is only 3 bits long and carries no channel bits.
- R8: Suppose the upstream serial input presents bit n after edge E(n+1), counted from the read. Then upstream bit n appears on the output directly after the record, at position len+n. The upstream input value sampled at E1 is dropped.
- R9: Before any read, the selected serial output repeats the upstream serial input, delayed by one clock. The unselected serial output is always 0.
- R10: If a read and a trigger acknowledge address the same buffer in the same cycle, the read returns the previous contents.
- R11: While `rst` is high and after it is released, all four outputs are 0 until they are driven by an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 64 | Discriminator outputs, one per channel |
| trig_mask_i | input | 64 | 1 blocks the channel from the trigger OR |
| data_mask_i | input | 64 | 1 blocks the channel from stored event data |
| dir_right_i | input | 1 | 1 sends OR and data to the right, 0 to the left |
| or_from_left_i | input | 1 | OR from the left neighbour |
| or_from_right_i | input | 1 | OR from the right neighbour |
| or_to_left_o | output | 1 | Chained OR toward the left |
| or_to_right_o | output | 1 | Chained OR toward the right |
| ack_i | input | 1 | Trigger-acknowledge strobe |
| ack_code_i | input | 2 | Buffer code for the acknowledge |
| rd_i | input | 1 | Read-event strobe |
| rd_addr_i | input | 2 | Buffer to read |
| ser_from_left_i | input | 1 | Serial stream from the left neighbour |
| ser_from_right_i | input | 1 | Serial stream from the right neighbour |
| ser_to_left_o | output | 1 | Serial stream toward the left |
| ser_to_right_o | output | 1 | Serial stream toward the right |

## Verification
The bench sweeps every channel, in both directions, with its trigger-mask bit on and off and with the neighbour OR on and off. A design with an inverted mask or a wrong side selection fails at once. Every buffer is read in turn, including a word that is fully masked and must produce the 3-bit record, and a word whose only hit is channel 63. A design that always sends 67 bits, or that reverses the bit order, puts the upstream stream in the wrong place. The upstream bit sampled in the cycle right after the load must be dropped, and the first real upstream bit must follow the record with no gap. An off-by-one in the insertion point shifts the whole forwarded stream. A read in the same cycle as an overwrite must return the old contents, which catches a write-first buffer.

// File: rtl/strip_fe_pkg.sv
package strip_fe_pkg;
  localparam int CODE_W = 2;
  localparam int NBUF   = 1 << CODE_W;
  localparam int HDR_W  = 1 + CODE_W;
endpackage

// File: rtl/fe_trig_chain.sv
module fe_trig_chain #(
  parameter int NCH = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] hit_i,
  input  logic [NCH-1:0] mask_i,
  input  logic           dir_i,
  input  logic           or_l_i,
  input  logic           or_r_i,
  output logic           or_l_o,
  output logic           or_r_o
);
  logic local_or;
  logic or_l_q, or_r_q;

  always_comb local_or = |(hit_i & ~mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      or_l_q <= 1'b0;
      or_r_q <= 1'b0;
    end else begin
      or_r_q <= dir_i & (local_or | or_l_i);
      or_l_q <= ~dir_i & (local_or | or_r_i);
    end
  end

  assign or_l_o = or_l_q;
  assign or_r_o = or_r_q;

  p_one_side_r2: assert property (@(posedge clk) disable iff (rst)
    !(or_l_o && or_r_o));
  p_pass_right_r3: assert property (@(posedge clk) disable iff (rst)
    (dir_i && or_l_i) |=> or_r_o);
  p_pass_left_r3: assert property (@(posedge clk) disable iff (rst)
    (!dir_i && or_r_i) |=> or_l_o);
endmodule

// File: rtl/fe_event_store.sv
module fe_event_store
  import strip_fe_pkg::*;
#(
  parameter int NCH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_i,
  input  logic [CODE_W-1:0] ack_code_i,
  input  logic [NCH-1:0]    hit_i,
  input  logic [NCH-1:0]    dmask_i,
  input  logic [CODE_W-1:0] rd_addr_i,
  output logic [NCH-1:0]    rd_word_o,
  output logic [CODE_W-1:0] rd_code_o
);
  localparam int ENT_W = NCH + CODE_W;

  logic [ENT_W-1:0] mem [NBUF];

  always_ff @(posedge clk) begin
    if (ack_i) mem[ack_code_i] <= {ack_code_i, hit_i & ~dmask_i};
  end

  assign rd_word_o = mem[rd_addr_i][NCH-1:0];
  assign rd_code_o = mem[rd_addr_i][ENT_W-1:NCH];

  p_code_kept_r4: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> (mem[$past(ack_code_i)][ENT_W-1:NCH] == $past(ack_code_i)));
endmodule

// File: rtl/fe_serial_link.sv
module fe_serial_link
  import strip_fe_pkg::*;
#(
  parameter int NCH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_i,
  input  logic              load_i,
  input  logic [NCH-1:0]    ld_word_i,
  input  logic [CODE_W-1:0] ld_code_i,
  input  logic              ser_l_i,
  input  logic              ser_r_i,
  output logic              ser_l_o,
  output logic              ser_r_o
);
  localparam int REC_W = HDR_W + NCH;
  localparam int CW    = $clog2(REC_W + 1);

  logic [REC_W-1:0] sr, sr_n, rec;
  logic [CW-1:0]    cnt, cnt_n, len;
  logic             fresh;
  logic             up_bit, nxt_bit, flag;
  logic             out_l_q, out_r_q;

  always_comb begin
    up_bit = dir_i ? ser_l_i : ser_r_i;
    flag   = |ld_word_i;
    rec    = '0;
    rec[0] = flag;
    for (int j = 0; j < CODE_W; j++) rec[1 + j] = ld_code_i[CODE_W - 1 - j];
    rec[REC_W-1:HDR_W] = ld_word_i;
    len    = flag ? CW'(REC_W) : CW'(HDR_W);
  end

  always_comb begin
    nxt_bit = (cnt == '0) ? up_bit : sr[0];
    sr_n    = sr >> 1;
    cnt_n   = cnt;
    if (fresh) begin
      cnt_n = cnt - CW'(1);
    end else if (cnt != '0) begin
      for (int i = 0; i < REC_W; i++)
        if (i == int'(cnt) - 1) sr_n[i] = up_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      cnt     <= '0;
      fresh   <= 1'b0;
      out_l_q <= 1'b0;
      out_r_q <= 1'b0;
    end else begin
      out_r_q <= dir_i & nxt_bit;
      out_l_q <= ~dir_i & nxt_bit;
      if (load_i) begin
        sr    <= rec;
        cnt   <= len;
        fresh <= 1'b1;
      end else begin
        sr    <= sr_n;
        cnt   <= cnt_n;
        fresh <= 1'b0;
      end
    end
  end

  assign ser_l_o = out_l_q;
  assign ser_r_o = out_r_q;

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) || (cnt >= CW'(CODE_W) && cnt <= CW'(REC_W)));
  p_one_side_r9: assert property (@(posedge clk) disable iff (rst)
    !(ser_l_o && ser_r_o));
  p_pass_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load_i && dir_i) |=> (ser_r_o == $past(ser_l_i)));
endmodule

// File: rtl/strip_fe_core.sv
module strip_fe_core
  import strip_fe_pkg::*;
#(
  parameter int NCH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    hit_i,
  input  logic [NCH-1:0]    trig_mask_i,
  input  logic [NCH-1:0]    data_mask_i,
  input  logic              dir_right_i,
  input  logic              or_from_left_i,
  input  logic              or_from_right_i,
  output logic              or_to_left_o,
  output logic              or_to_right_o,
  input  logic              ack_i,
  input  logic [CODE_W-1:0] ack_code_i,
  input  logic              rd_i,
  input  logic [CODE_W-1:0] rd_addr_i,
  input  logic              ser_from_left_i,
  input  logic              ser_from_right_i,
  output logic              ser_to_left_o,
  output logic              ser_to_right_o
);
  logic [NCH-1:0]    rd_word;
  logic [CODE_W-1:0] rd_code;

  fe_trig_chain #(.NCH(NCH)) u_trig (
    .clk(clk), .rst(rst), .hit_i(hit_i), .mask_i(trig_mask_i),
    .dir_i(dir_right_i), .or_l_i(or_from_left_i), .or_r_i(or_from_right_i),
    .or_l_o(or_to_left_o), .or_r_o(or_to_right_o)
  );

  fe_event_store #(.NCH(NCH)) u_store (
    .clk(clk), .rst(rst), .ack_i(ack_i), .ack_code_i(ack_code_i),
    .hit_i(hit_i), .dmask_i(data_mask_i), .rd_addr_i(rd_addr_i),
    .rd_word_o(rd_word), .rd_code_o(rd_code)
  );

  fe_serial_link #(.NCH(NCH)) u_link (
    .clk(clk), .rst(rst), .dir_i(dir_right_i), .load_i(rd_i),
    .ld_word_i(rd_word), .ld_code_i(rd_code),
    .ser_l_i(ser_from_left_i), .ser_r_i(ser_from_right_i),
    .ser_l_o(ser_to_left_o), .ser_r_o(ser_to_right_o)
  );
endmodule

// File: tb/sim_strip_fe_core.sv
module sim_strip_fe_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] hit = '0, tmask = '0, dmask = '0;
  logic        dir = 1'b1;
  logic        orl = 1'b0, orr = 1'b0;
  logic        ack = 1'b0, rd = 1'b0;
  logic [1:0]  acode = '0, raddr = '0;
  logic        sl = 1'b0, srr = 1'b0;
  logic        or_lo, or_ro, s_lo, s_ro;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  strip_fe_core u0 (
    .clk(clk), .rst(rst), .hit_i(hit), .trig_mask_i(tmask), .data_mask_i(dmask),
    .dir_right_i(dir), .or_from_left_i(orl), .or_from_right_i(orr),
    .or_to_left_o(or_lo), .or_to_right_o(or_ro),
    .ack_i(ack), .ack_code_i(acode), .rd_i(rd), .rd_addr_i(raddr),
    .ser_from_left_i(sl), .ser_from_right_i(srr),
    .ser_to_left_o(s_lo), .ser_to_right_o(s_ro)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int seed);
    logic [63:0] w;
    for (int i = 0; i < 64; i++) w[i] = (((i * seed) + (seed >> 1)) % 5) == 0;
    return w;
  endfunction

  function automatic bit up_pat(input int n);
    return (((n * 7) + 3) % 5) < 2;
  endfunction

  function automatic bit rec_bit(input int k, input logic [63:0] w, input logic [1:0] c);
    if (k == 0) return |w;
    if (k == 1) return c[1];
    if (k == 2) return c[0];
    return w[k-3];
  endfunction

  task automatic set_up(input bit b);
    if (dir) begin sl = b; srr = 1'b1; end
    else begin srr = b; sl = 1'b1; end
  endtask

  task automatic do_ack(input logic [1:0] c, input logic [63:0] h, input logic [63:0] dm);
    @(negedge clk);
    ack = 1'b1; acode = c; hit = h; dmask = dm;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, input bit d, input logic [63:0] w,
                         input logic [1:0] c, input string req);
    int len;
    len = (|w) ? 67 : 3;
    @(negedge clk);
    rd = 1'b1; raddr = a; dir = d;
    set_up(1'b1);
    @(negedge clk);
    rd = 1'b0;
    for (int k = 0; k < len + 24; k++) begin
      bit exp_b, act_b, oth;
      @(negedge clk);
      exp_b = (k < len) ? rec_bit(k, w, c) : up_pat(k - len);
      act_b = d ? s_ro : s_lo;
      oth   = d ? s_lo : s_ro;
      chk(act_b == exp_b, (k < len) ? req : "R8 upstream follows record",
          64'(act_b), 64'(exp_b));
      chk(oth == 1'b0, "R9 unselected serial side is 0", 64'(oth), 64'd0);
      set_up(up_pat(k));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] wa, wb, bm, wc, wd, we, wf;
    repeat (3) @(negedge clk);
    chk({or_lo, or_ro, s_lo, s_ro} == 4'b0, "R11 outputs low in reset",
        64'({or_lo, or_ro, s_lo, s_ro}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk({or_lo, or_ro, s_lo, s_ro} == 4'b0, "R11 outputs low after reset",
        64'({or_lo, or_ro, s_lo, s_ro}), 64'd0);

    // R9: idle forwarding, both directions
    for (int d = 0; d < 2; d++) begin
      dir = d[0];
      for (int k = 0; k < 20; k++) begin
        bit b;
        b = up_pat(k + d);
        set_up(b);
        @(negedge clk);
        chk((d ? s_ro : s_lo) == b, "R9 idle forward one cycle", 64'(d ? s_ro : s_lo), 64'(b));
        chk((d ? s_lo : s_ro) == 1'b0, "R9 idle other side 0", 64'(d ? s_lo : s_ro), 64'd0);
      end
    end
    sl = 1'b0; srr = 1'b0;

    // R1/R2/R3: OR chain sweep
    for (int d = 0; d < 2; d++)
      for (int ch = 0; ch < 64; ch++)
        for (int m = 0; m < 2; m++)
          for (int nb = 0; nb < 2; nb++) begin
            bit e;
            dir   = ((ch + m + nb + d) % 2) == 1;
            hit   = 64'd1 << ch;
            tmask = (pat(ch + 3) & ~(64'd1 << ch)) | (64'(m) << ch);
            if (dir) begin orl = nb[0]; orr = 1'b1; end
            else begin orr = nb[0]; orl = 1'b1; end
            @(negedge clk);
            e = (m == 0) || (nb == 1);
            chk((dir ? or_ro : or_lo) == e, "R1 R2 R3 chained OR selected side",
                64'(dir ? or_ro : or_lo), 64'(e));
            chk((dir ? or_lo : or_ro) == 1'b0, "R2 unselected OR side 0",
                64'(dir ? or_lo : or_ro), 64'd0);
          end
    hit = '1; tmask = '1; orl = 1'b0; orr = 1'b0; dir = 1'b1;
    @(negedge clk);
    chk(or_ro == 1'b0, "R1 all channels masked", 64'(or_ro), 64'd0);
    tmask = ~(64'd1 << 63);
    @(negedge clk);
    chk(or_ro == 1'b1, "R1 only channel 63 open", 64'(or_ro), 64'd1);

    // R4/R5/R6/R7: event buffers
    wa = pat(7); wb = pat(11); bm = pat(4); wc = pat(13); wd = 64'd1 << 63;
    tmask = '0;
    do_ack(2'd0, wa, 64'd0);
    do_ack(2'd1, wb, bm);
    do_ack(2'd2, wc, wc);
    tmask = '1;
    do_ack(2'd3, wd, 64'd0);
    hit = '0;
    do_read(2'd0, 1'b1, wa, 2'd0, "R6 record buffer 0");
    do_read(2'd1, 1'b0, wb & ~bm, 2'd1, "R5 R6 masked record buffer 1");
    do_read(2'd2, 1'b1, 64'd0, 2'd2, "R7 empty record is 3 bits");
    do_read(2'd3, 1'b0, wd, 2'd3, "R5 R6 channel 63 record");
    we = pat(17);
    do_ack(2'd1, we, 64'd0);
    do_read(2'd1, 1'b1, we, 2'd1, "R4 overwrite buffer 1");

    // R10: read and overwrite of the same buffer in one cycle
    wf = pat(19);
    @(negedge clk);
    ack = 1'b1; acode = 2'd2; hit = wf; dmask = '0;
    rd = 1'b1; raddr = 2'd2; dir = 1'b1; set_up(1'b1);
    @(negedge clk);
    ack = 1'b0; rd = 1'b0;
    for (int k = 0; k < 3 + 8; k++) begin
      bit e;
      @(negedge clk);
      e = (k < 3) ? rec_bit(k, 64'd0, 2'd2) : up_pat(k - 3);
      chk(s_ro == e, "R10 read returns old contents", 64'(s_ro), 64'(e));
      set_up(up_pat(k));
    end
    do_read(2'd2, 1'b0, wf, 2'd2, "R10 new contents after write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule